// File: doc/BRIEF.md
# Periodic Complex Subband Demodulator

This block sits directly behind one bandpass sigma-delta channel and moves that channel's subband down to baseband. Each 3-bit quantizer code is turned into an odd signed level. The level is then multiplied by a complex exponential, cos(2πfn) − j·sin(2πfn), whose frequency f is a rational fraction p/q of the sample rate. The result is an in-phase stream and a quadrature stream at full precision. Because f is rational, the exponential repeats every q samples. A modulo-q phase counter indexes a small register table of signed 11-bit cosine and sine words. Both the table and the period can be rewritten at run time, which lets a recalibrated centre frequency be followed.

The datapath contains no multipliers. Every product is formed by a short chain of shifted additions, one term per input code bit. The output streams use a valid/ready handshake. The block accepts a sample when `s_valid` and `s_ready` are both high. `s_ready` is high whenever the output register is empty or is being drained in the same cycle. While `m_valid` is high and `m_ready` is low, the output pair and `m_valid` hold their values and no new sample is taken.

Top module: `subband_demod`

## Requirements
- R1: After reset, `m_valid` is 0, `s_ready` is 1, the period is 1, the phase is 0 and every table entry holds cos = sin = 0.
- R2: A sample with code c, read at table entry k, yields `m_i` = (2c−7)·cos[k] and `m_q` = −(2c−7)·sin[k]. Both are 14-bit two's complement values, so code 0 maps to level −7 and code 7 maps to level +7.
- R3: A sample accepted at a rising edge appears on `m_i`/`m_q` with `m_valid` = 1 right after that same edge. If no sample is accepted while `s_ready` is 1, `m_valid` is 0 after the edge.
- R4: `s_ready` equals (not `m_valid`) or `m_ready`. While `m_valid` = 1 and `m_ready` = 0, `m_valid`, `m_i` and `m_q` stay unchanged.
- R5: The phase moves by one on each accepted sample and wraps from period−1 to 0. Without an accepted sample it holds.
- R6: A period load sets the phase to 0. A sample accepted in the same cycle still uses the old phase, and the next accepted sample uses entry 0.
- R7: A loaded period of 0 is stored as 1. A loaded period above the table depth (64) is stored as 64.
- R8: A table write to entry k takes effect for samples accepted after the write edge. A sample accepted in the same cycle reads the old contents.
- R9: Extreme words are exact. Code 0 with a word of −1024 gives +7168, and code 7 with a word of −1024 gives −7168.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Input sample valid |
| s_ready | output | 1 | Block can take a sample |
| s_code | input | 3 | Quantizer code 0..7 |
| m_valid | output | 1 | Output pair valid |
| m_ready | input | 1 | Downstream takes the pair |
| m_i | output | 14 | In-phase product, signed |
| m_q | output | 14 | Quadrature product, signed |
| cfg_period_we | input | 1 | Load a new period |
| cfg_period | input | 7 | New period q |
| cfg_tab_we | input | 1 | Write one table entry |
| cfg_tab_addr | input | 6 | Entry index |
| cfg_tab_cos | input | 11 | Signed cosine word |
| cfg_tab_sin | input | 11 | Signed sine word |

## Verification
A phase counter that drifts by even one step shows up at once: the next output pair uses the wrong table entry. That sample comes from a table where every entry holds distinct words, so the error is visible at the ports. A period that is clamped wrongly or a wrap that comes late surfaces at the first sample past the boundary. A level mapping or shift-add term that is wrong corrupts the product on the very cycle after acceptance, and the bench sweeps all eight codes to expose it. Handshake faults appear as a changed output during a stall, or as `s_ready` disagreeing with the drain rule on that same cycle.

// File: rtl/demod_pkg.sv
package demod_pkg;
  localparam int CODE_W = 3;
  localparam int COEF_W = 11;
  localparam int PROD_W = CODE_W + COEF_W;

  function automatic int period_clamp(input int val, input int max_p);
    if (val < 1) return 1;
    if (val > max_p) return max_p;
    return val;
  endfunction
endpackage

// File: rtl/demod_phase_ctr.sv
module demod_phase_ctr #(
  parameter int MAX_PERIOD = 64,
  localparam int IDX_W = $clog2(MAX_PERIOD),
  localparam int PER_W = $clog2(MAX_PERIOD + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             load,
  input  logic [PER_W-1:0] load_val,
  output logic [IDX_W-1:0] phase
);
  logic [PER_W-1:0] per_q;
  logic [IDX_W-1:0] phase_q;
  logic [PER_W-1:0] nxt;

  assign nxt   = PER_W'(phase_q) + PER_W'(1);
  assign phase = phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      per_q   <= PER_W'(1);
      phase_q <= '0;
    end else if (load) begin
      per_q   <= PER_W'(demod_pkg::period_clamp(int'(load_val), MAX_PERIOD));
      phase_q <= '0;
    end else if (adv) begin
      phase_q <= (nxt >= per_q) ? '0 : IDX_W'(nxt);
    end
  end

  AST_PHASE_BELOW_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    PER_W'(phase_q) < per_q); // R5
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !adv) |=> $stable(phase_q)); // R5
  AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (phase_q == '0)); // R6
  AST_PERIOD_CLAMPED: assert property (@(posedge clk) disable iff (!rst_n)
    (per_q >= PER_W'(1)) && (per_q <= PER_W'(MAX_PERIOD))); // R7
endmodule

// File: rtl/demod_coef_table.sv
module demod_coef_table #(
  parameter int DEPTH  = 64,
  parameter int COEF_W = demod_pkg::COEF_W,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [IDX_W-1:0]         wr_addr,
  input  logic signed [COEF_W-1:0] wr_cos,
  input  logic signed [COEF_W-1:0] wr_sin,
  input  logic [IDX_W-1:0]         rd_addr,
  output logic signed [COEF_W-1:0] rd_cos,
  output logic signed [COEF_W-1:0] rd_sin
);
  logic signed [COEF_W-1:0] cos_r [DEPTH];
  logic signed [COEF_W-1:0] sin_r [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cos_r[e] <= '0;
        sin_r[e] <= '0;
      end else if (wr_en && (int'(wr_addr) == e)) begin
        cos_r[e] <= wr_cos;
        sin_r[e] <= wr_sin;
      end
    end
  end

  always_comb begin
    rd_cos = '0;
    rd_sin = '0;
    if (int'(rd_addr) < DEPTH) begin
      rd_cos = cos_r[rd_addr];
      rd_sin = sin_r[rd_addr];
    end
  end
endmodule

// File: rtl/demod_shift_add.sv
module demod_shift_add #(
  parameter int CODE_W = demod_pkg::CODE_W,
  parameter int COEF_W = demod_pkg::COEF_W,
  localparam int PROD_W = CODE_W + COEF_W
) (
  input  logic [CODE_W-1:0]        code,
  input  logic signed [COEF_W-1:0] coef,
  output logic signed [PROD_W-1:0] prod
);
  // level = 2*code - (2^CODE_W - 1); product built from shifted copies
  localparam int LIM = ((1 << CODE_W) - 1) * (1 << (COEF_W - 1));

  logic signed [PROD_W-1:0] ext;
  logic signed [PROD_W-1:0] term [CODE_W];

  assign ext = PROD_W'(coef);

  for (genvar b = 0; b < CODE_W; b++) begin : g_term
    assign term[b] = code[b] ? (ext <<< (b + 1)) : '0;
  end

  always_comb begin
    prod = ext - (ext <<< CODE_W);
    for (int b = 0; b < CODE_W; b++) prod = prod + term[b];
  end

  always_comb begin
    AST_PROD_BOUND: assert ((int'(prod) <= LIM) && (int'(prod) >= -LIM)); // R9
  end
endmodule

// File: rtl/subband_demod.sv
module subband_demod #(
  parameter int MAX_PERIOD = 64,
  parameter int CODE_W = demod_pkg::CODE_W,
  parameter int COEF_W = demod_pkg::COEF_W,
  localparam int IDX_W  = $clog2(MAX_PERIOD),
  localparam int PER_W  = $clog2(MAX_PERIOD + 1),
  localparam int PROD_W = CODE_W + COEF_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     s_valid,
  output logic                     s_ready,
  input  logic [CODE_W-1:0]        s_code,
  output logic                     m_valid,
  input  logic                     m_ready,
  output logic signed [PROD_W-1:0] m_i,
  output logic signed [PROD_W-1:0] m_q,
  input  logic                     cfg_period_we,
  input  logic [PER_W-1:0]         cfg_period,
  input  logic                     cfg_tab_we,
  input  logic [IDX_W-1:0]         cfg_tab_addr,
  input  logic signed [COEF_W-1:0] cfg_tab_cos,
  input  logic signed [COEF_W-1:0] cfg_tab_sin
);
  logic                     take;
  logic [IDX_W-1:0]         phase;
  logic signed [COEF_W-1:0] cos_w, sin_w;
  logic signed [PROD_W-1:0] prod_i, prod_q;

  assign s_ready = !m_valid || m_ready;
  assign take    = s_valid && s_ready;

  demod_phase_ctr #(.MAX_PERIOD(MAX_PERIOD)) u_phase (
    .clk(clk), .rst_n(rst_n), .adv(take),
    .load(cfg_period_we), .load_val(cfg_period), .phase(phase)
  );

  demod_coef_table #(.DEPTH(MAX_PERIOD), .COEF_W(COEF_W)) u_table (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_tab_we), .wr_addr(cfg_tab_addr),
    .wr_cos(cfg_tab_cos), .wr_sin(cfg_tab_sin),
    .rd_addr(phase), .rd_cos(cos_w), .rd_sin(sin_w)
  );

  demod_shift_add #(.CODE_W(CODE_W), .COEF_W(COEF_W)) u_mul_i (
    .code(s_code), .coef(cos_w), .prod(prod_i)
  );

  // inverting the code negates the odd level, giving -level*sin
  demod_shift_add #(.CODE_W(CODE_W), .COEF_W(COEF_W)) u_mul_q (
    .code(~s_code), .coef(sin_w), .prod(prod_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_i     <= '0;
      m_q     <= '0;
    end else if (s_ready) begin
      m_valid <= s_valid;
      if (s_valid) begin
        m_i <= prod_i;
        m_q <= prod_q;
      end
    end
  end

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_i) && $stable(m_q))); // R4
  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> m_valid); // R3
  AST_EMPTY_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!s_valid && s_ready) |=> !m_valid); // R3
endmodule

// File: tb/subband_demod_test.sv
module subband_demod_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s_valid = 1'b0, m_ready = 1'b1;
  logic [2:0] s_code = '0;
  logic s_ready, m_valid;
  logic signed [13:0] m_i, m_q;
  logic cfg_period_we = 1'b0, cfg_tab_we = 1'b0;
  logic [6:0] cfg_period = '0;
  logic [5:0] cfg_tab_addr = '0;
  logic signed [10:0] cfg_tab_cos = '0, cfg_tab_sin = '0;

  int checks = 0, failures = 0;
  int cos_m [64], sin_m [64];
  int per_m = 1, ph_m = 0, ei = 0, eq = 0;
  bit mv_m = 0;

  always #10 clk = ~clk;

  subband_demod uut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready), .s_code(s_code),
    .m_valid(m_valid), .m_ready(m_ready), .m_i(m_i), .m_q(m_q),
    .cfg_period_we(cfg_period_we), .cfg_period(cfg_period), .cfg_tab_we(cfg_tab_we),
    .cfg_tab_addr(cfg_tab_addr), .cfg_tab_cos(cfg_tab_cos), .cfg_tab_sin(cfg_tab_sin)
  );

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input bit v, input int c, input bit rdy, input bit pwe, input int pval,
                      input bit twe, input int ta, input int tc, input int ts, input string tag);
    bit acc, er;
    int lvl;
    s_valid = v; s_code = 3'(c); m_ready = rdy;
    cfg_period_we = pwe; cfg_period = 7'(pval);
    cfg_tab_we = twe; cfg_tab_addr = 6'(ta); cfg_tab_cos = 11'(tc); cfg_tab_sin = 11'(ts);
    #1;
    er = !mv_m || rdy;
    chk(int'(s_ready), int'(er), "R4 ready rule");
    acc = v && er;
    if (acc) begin
      lvl = 2 * c - 7;
      ei = lvl * cos_m[ph_m];
      eq = -lvl * sin_m[ph_m];
      mv_m = 1;
    end else if (er) mv_m = 0;
    if (twe) begin cos_m[ta] = tc; sin_m[ta] = ts; end
    if (pwe) begin
      per_m = (pval == 0) ? 1 : ((pval > 64) ? 64 : pval);
      ph_m = 0;
    end else if (acc) ph_m = (ph_m + 1 >= per_m) ? 0 : ph_m + 1;
    @(posedge clk); @(negedge clk);
    chk(int'(m_valid), int'(mv_m), {tag, " valid"});
    if (mv_m) begin
      chk(int'(m_i), ei, {tag, " I"});
      chk(int'(m_q), eq, {tag, " Q"});
    end
    s_valid = 0; m_ready = 1; cfg_period_we = 0; cfg_tab_we = 0;
  endtask

  task automatic send(input int c, input string tag);
    step(1, c, 1, 0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic t_reset;
    chk(int'(m_valid), 0, "R1 valid after reset");
    chk(int'(s_ready), 1, "R1 ready after reset");
    send(7, "R1 zero table");
    send(0, "R1 zero table");
  endtask

  task automatic t_fill;
    for (int k = 0; k < 64; k++)
      step(0, 0, 1, 0, 0, 1, k, k * 13 - 400, 350 - k * 11, "R8 fill");
  endtask

  task automatic t_codes;
    step(0, 0, 1, 1, 8, 0, 0, 0, 0, "R6 load 8");
    for (int c = 0; c < 8; c++) send(c, "R2 code sweep");
    for (int c = 7; c >= 0; c--) send(c, "R5 wrap at 8");
  endtask

  task automatic t_idle;
    step(0, 0, 1, 1, 3, 0, 0, 0, 0, "R6 load 3");
    send(5, "R5 advance");
    for (int n = 0; n < 3; n++) step(0, 0, 1, 0, 0, 0, 0, 0, 0, "R3 idle empty");
    send(6, "R5 hold while idle");
    send(1, "R5 wrap at 3");
    send(2, "R5 after wrap");
  endtask

  task automatic t_reload;
    send(4, "R6 pre");
    step(1, 3, 1, 1, 5, 0, 0, 0, 0, "R6 load with sample");
    send(3, "R6 entry 0 after load");
    send(2, "R6 entry 1");
  endtask

  task automatic t_clamp;
    step(0, 0, 1, 1, 0, 0, 0, 0, 0, "R7 load 0");
    send(6, "R7 period one");
    send(2, "R7 period one");
    step(0, 0, 1, 1, 100, 0, 0, 0, 0, "R7 load 100");
    for (int n = 0; n < 66; n++) send((n * 3) % 8, "R7 clamp 64");
  endtask

  task automatic t_stall;
    step(0, 0, 1, 1, 4, 0, 0, 0, 0, "R4 setup");
    send(6, "R4 first");
    step(1, 1, 0, 0, 0, 0, 0, 0, 0, "R4 stalled");
    step(1, 2, 0, 0, 0, 0, 0, 0, 0, "R4 stalled");
    step(1, 2, 1, 0, 0, 0, 0, 0, 0, "R4 drain and take");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R4 hold no input");
    step(0, 0, 1, 0, 0, 0, 0, 0, 0, "R3 drain to empty");
  endtask

  task automatic t_write_timing;
    step(0, 0, 1, 1, 2, 0, 0, 0, 0, "R8 setup");
    step(1, 5, 1, 0, 0, 1, 0, 999, -777, "R8 same-cycle write");
    send(5, "R8 entry 1");
    send(5, "R8 new entry 0");
  endtask

  task automatic t_extreme;
    step(0, 0, 1, 1, 1, 1, 0, -1024, -1024, "R9 setup");
    send(0, "R9 code 0");
    send(7, "R9 code 7");
    step(0, 0, 1, 0, 0, 1, 0, 1023, 1023, "R9 setup");
    send(0, "R9 max word");
    send(7, "R9 max word");
  endtask

  initial begin
    #(20 * 100000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int k = 0; k < 64; k++) begin cos_m[k] = 0; sin_m[k] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_fill();
    t_codes();
    t_idle();
    t_reload();
    t_clamp();
    t_stall();
    t_write_timing();
    t_extreme();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule